// File: doc/BRIEF.md
# Wide Register Write Collector

The collector sits between a host write bus that works in 32-bit units and a bank of 128-bit control registers. The host may write a register one dword at a time, as two 64-bit halves, or in one beat carrying three or four dwords. The collector gathers the low three dwords of one register in a holding buffer. When a write carries the top dword (bits 127:96), the whole register is written at once. Low dwords that neither the buffer nor that write supplied are written as zero.

Each host beat names a register index and carries four dword lanes. Lane k always holds dword k of the register (bits 32k+31:32k), and the per-lane enable `host_en[k]` says whether that lane is present. While the buffer holds data for one register, low-dword writes to any other register are dropped.

The buffer is controlled by a two-state machine:
- `BUF_EMPTY` moves to `BUF_FILLING` (transition *capture*) on a low-only write, and records the register index as the tag.
- `BUF_FILLING` stays in `BUF_FILLING` on a low-only write. A write to the tagged register is *merged*. A write to any other register is *dropped*.
- Any write with lane 3 enabled causes a *commit*. From `BUF_FILLING` this moves the machine back to `BUF_EMPTY`. In `BUF_EMPTY` it leaves the state unchanged.

The commit is presented for one cycle on the commit port and written into a small register array. The array can be inspected through a peek port.

Top module: `wide_reg_collector`

## Requirements
- R1: After synchronous active-high reset, every register in the array reads zero, `commit_vld` is low and the buffer is empty.
- R2: A beat with `host_vld` and `host_en[3]` set raises `commit_vld` in the next cycle. In that cycle `commit_idx` is the beat's register index and `commit_data[127:96]` is lane 3. The array entry reads the same 128-bit value.
- R3: At commit, a low dword (0 to 2) is taken from the beat if its lane is enabled. Otherwise it is taken from the buffer if the buffer is tagged with the same register and holds that dword. Otherwise it is zero.
- R4: A beat with no lane 3 but some low lane enabled, arriving while the buffer is empty, stores the enabled dwords and tags the buffer with the beat's index. It produces no commit.
- R5: A low-only beat to the tagged register overwrites the matching buffered dwords and adds them to the held set. Dwords it does not carry are kept.
- R6: A low-only beat to a register other than the tag, while the buffer is filling, is discarded. The buffered dwords and the tag stay unchanged.
- R7: A single beat carrying three or four dwords of one register is merged and committed as if those dwords had arrived separately.
- R8: A register written as two 64-bit halves (lanes 0 and 1 first, then lanes 2 and 3) commits the full 128-bit value on the second half.
- R9: `commit_vld` is high for exactly one cycle per top-dword beat, and the buffer is empty after every commit. A following low-only beat to any register is therefore captured.
- R10: A top-dword beat to a register other than the tag takes no dwords from the buffer. Its missing low dwords are zero, and it still empties the buffer.
- R11: A beat with `host_vld` high and no lane enabled changes nothing and produces no commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_vld | input | 1 | Host write beat present |
| host_idx | input | IDX_W | Target register index |
| host_data | input | 4*DWORD_W | Four dword lanes, lane k = dword k |
| host_en | input | 4 | Per-lane enables |
| commit_vld | output | 1 | One-cycle commit strobe |
| commit_idx | output | IDX_W | Committed register index |
| commit_data | output | 4*DWORD_W | Merged register value |
| peek_idx | input | IDX_W | Array entry to observe |
| peek_data | output | 4*DWORD_W | Current contents of that entry |

## Verification
The bench targets these corner cases:
- **Discarded writes to another register while the buffer is filling.** A design that overwrote the buffer or retagged it would commit foreign dwords.
- **Top-dword beats to a register other than the tag.** A design that merged without comparing tags would leak stale data, and one that failed to clear the buffer would later discard legitimate captures.
- **Zero fill of untouched low dwords.** A design that kept old array contents would be caught here, as would one that committed on a low dword.
- **Multi-dword beats and the two-half pattern,** checked with the strobe, index and full value compared each cycle.

A long constrained-random run over a few register indices exercises tag hits and misses heavily.

// File: rtl/wcol_pkg.sv
package wcol_pkg;

    localparam int LANES = 4;
    localparam int LOW_LANES = LANES - 1;

    typedef enum logic {
        BUF_EMPTY   = 1'b0,
        BUF_FILLING = 1'b1
    } buf_state_t;

endpackage

// File: rtl/wcol_buffer.sv
module wcol_buffer
    import wcol_pkg::*;
#(
    parameter int DWORD_W = 32,
    parameter int IDX_W   = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           host_vld,
    input  logic [IDX_W-1:0]               host_idx,
    input  logic [LOW_LANES*DWORD_W-1:0]   host_low,
    input  logic [LANES-1:0]               host_en,
    output logic                           buf_hit,
    output logic [LOW_LANES-1:0]           buf_mask,
    output logic [LOW_LANES*DWORD_W-1:0]   buf_data
);

    buf_state_t             state_q, state_d;
    logic [IDX_W-1:0]       tag_q;
    logic                   top_beat;
    logic                   low_beat;
    logic                   take_beat;

    assign top_beat = host_vld && host_en[LANES-1];
    assign low_beat = host_vld && !host_en[LANES-1] && (|host_en[LOW_LANES-1:0]);

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUF_EMPTY:   if (low_beat) state_d = BUF_FILLING;
            BUF_FILLING: if (top_beat) state_d = BUF_EMPTY;
            default:     state_d = BUF_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= BUF_EMPTY;
        else     state_q <= state_d;
    end

    // output / decode process
    always_comb begin
        buf_hit   = (state_q == BUF_FILLING) && (tag_q == host_idx);
        take_beat = low_beat && ((state_q == BUF_EMPTY) || buf_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q    <= '0;
            buf_mask <= '0;
        end else if (top_beat) begin
            tag_q    <= '0;
            buf_mask <= '0;
        end else if (take_beat) begin
            tag_q <= host_idx;
            if (state_q == BUF_EMPTY) buf_mask <= host_en[LOW_LANES-1:0];
            else                      buf_mask <= buf_mask | host_en[LOW_LANES-1:0];
        end
    end

    for (genvar k = 0; k < LOW_LANES; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                buf_data[k*DWORD_W +: DWORD_W] <= '0;
            else if (take_beat && host_en[k])
                buf_data[k*DWORD_W +: DWORD_W] <= host_low[k*DWORD_W +: DWORD_W];
        end
    end

    // R1
    mask_state_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == BUF_EMPTY) == (buf_mask == '0));

    // R4
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == BUF_EMPTY && low_beat) |=>
        (state_q == BUF_FILLING && tag_q == $past(host_idx)
         && buf_mask == $past(host_en[LOW_LANES-1:0])));

    // R6
    discard_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == BUF_FILLING && low_beat && tag_q != host_idx) |=>
        ($stable(buf_mask) && $stable(tag_q) && $stable(buf_data)));

    // R9
    commit_empties_chk: assert property (@(posedge clk) disable iff (rst)
        top_beat |=> (state_q == BUF_EMPTY && buf_mask == '0));

endmodule

// File: rtl/wcol_merge.sv
module wcol_merge
    import wcol_pkg::*;
#(
    parameter int DWORD_W = 32
) (
    input  logic [LANES*DWORD_W-1:0]       host_data,
    input  logic [LANES-1:0]               host_en,
    input  logic                           buf_hit,
    input  logic [LOW_LANES-1:0]           buf_mask,
    input  logic [LOW_LANES*DWORD_W-1:0]   buf_data,
    output logic [LANES*DWORD_W-1:0]       merged
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        if (k == LANES - 1) begin : g_top
            assign merged[k*DWORD_W +: DWORD_W] = host_data[k*DWORD_W +: DWORD_W];
        end else begin : g_low
            always_comb begin
                if (host_en[k])
                    merged[k*DWORD_W +: DWORD_W] = host_data[k*DWORD_W +: DWORD_W];
                else if (buf_hit && buf_mask[k])
                    merged[k*DWORD_W +: DWORD_W] = buf_data[k*DWORD_W +: DWORD_W];
                else
                    merged[k*DWORD_W +: DWORD_W] = '0;
            end
        end
    end

endmodule

// File: rtl/wcol_bank.sv
module wcol_bank #(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 128,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_go,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [REG_W-1:0]  wr_val,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [REG_W-1:0]  rd_val
);

    logic [REG_W-1:0] mem_q [NUM_REGS];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                mem_q[r] <= '0;
            else if (wr_go && wr_idx == IDX_W'(r))
                mem_q[r] <= wr_val;
        end
    end

    assign rd_val = (int'(rd_idx) < NUM_REGS) ? mem_q[rd_idx] : '0;

    // R2
    bank_update_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_go && int'(wr_idx) < NUM_REGS) |=> (mem_q[$past(wr_idx)] == $past(wr_val)));

endmodule

// File: rtl/wide_reg_collector.sv
module wide_reg_collector
    import wcol_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DWORD_W  = 32,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int REG_W   = LANES * DWORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_vld,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [REG_W-1:0]  host_data,
    input  logic [LANES-1:0]  host_en,
    output logic              commit_vld,
    output logic [IDX_W-1:0]  commit_idx,
    output logic [REG_W-1:0]  commit_data,
    input  logic [IDX_W-1:0]  peek_idx,
    output logic [REG_W-1:0]  peek_data
);

    logic                         buf_hit;
    logic [LOW_LANES-1:0]         buf_mask;
    logic [LOW_LANES*DWORD_W-1:0] buf_data;
    logic [REG_W-1:0]             merged;
    logic                         top_beat;

    assign top_beat = host_vld && host_en[LANES-1];

    wcol_buffer #(.DWORD_W(DWORD_W), .IDX_W(IDX_W)) u_buffer (
        .clk      (clk),
        .rst      (rst),
        .host_vld (host_vld),
        .host_idx (host_idx),
        .host_low (host_data[LOW_LANES*DWORD_W-1:0]),
        .host_en  (host_en),
        .buf_hit  (buf_hit),
        .buf_mask (buf_mask),
        .buf_data (buf_data)
    );

    wcol_merge #(.DWORD_W(DWORD_W)) u_merge (
        .host_data (host_data),
        .host_en   (host_en),
        .buf_hit   (buf_hit),
        .buf_mask  (buf_mask),
        .buf_data  (buf_data),
        .merged    (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            commit_vld  <= 1'b0;
            commit_idx  <= '0;
            commit_data <= '0;
        end else begin
            commit_vld <= top_beat;
            if (top_beat) begin
                commit_idx  <= host_idx;
                commit_data <= merged;
            end
        end
    end

    wcol_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_go  (top_beat),
        .wr_idx (host_idx),
        .wr_val (merged),
        .rd_idx (peek_idx),
        .rd_val (peek_data)
    );

    // R2
    commit_follows_top_chk: assert property (@(posedge clk) disable iff (rst)
        top_beat |=> (commit_vld && commit_idx == $past(host_idx)
            && commit_data[REG_W-1 -: DWORD_W] == $past(host_data[REG_W-1 -: DWORD_W])));

    // R9
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        !top_beat |=> !commit_vld);

endmodule

// File: tb/test_wide_reg_collector.sv
module test_wide_reg_collector;

    localparam int NUM_REGS = 8;
    localparam int DW       = 32;
    localparam int IW       = 3;
    localparam int RW       = 4 * DW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_vld = 1'b0;
    logic [IW-1:0] host_idx = '0;
    logic [RW-1:0] host_data = '0;
    logic [3:0]    host_en = '0;
    logic          commit_vld;
    logic [IW-1:0] commit_idx;
    logic [RW-1:0] commit_data;
    logic [IW-1:0] peek_idx = '0;
    logic [RW-1:0] peek_data;

    int checks = 0;
    int fails  = 0;

    logic [RW-1:0] exp_regs [NUM_REGS];
    logic [2:0]    m_mask;
    logic [IW-1:0] m_tag;
    logic [DW-1:0] m_dw [3];

    always #10 clk = ~clk;

    wide_reg_collector #(.NUM_REGS(NUM_REGS), .DWORD_W(DW)) i_wide_reg_collector (
        .clk         (clk),
        .rst         (rst),
        .host_vld    (host_vld),
        .host_idx    (host_idx),
        .host_data   (host_data),
        .host_en     (host_en),
        .commit_vld  (commit_vld),
        .commit_idx  (commit_idx),
        .commit_data (commit_data),
        .peek_idx    (peek_idx),
        .peek_data   (peek_data)
    );

    function automatic logic [RW-1:0] model_merge(input logic [IW-1:0] idx,
                                                  input logic [3:0] en,
                                                  input logic [RW-1:0] d);
        logic [RW-1:0] r;
        r = '0;
        r[RW-1 -: DW] = d[RW-1 -: DW];
        for (int k = 0; k < 3; k++) begin
            if (en[k])                                   r[k*DW +: DW] = d[k*DW +: DW];
            else if (m_mask != 0 && m_tag == idx && m_mask[k]) r[k*DW +: DW] = m_dw[k];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic beat(input string req, input logic [IW-1:0] idx,
                        input logic [3:0] en, input logic [RW-1:0] d);
        logic          e_vld;
        logic [RW-1:0] e_val;
        e_vld = 1'b0;
        e_val = '0;
        host_vld  = 1'b1;
        host_idx  = idx;
        host_en   = en;
        host_data = d;
        peek_idx  = idx;
        if (en[3]) begin
            e_vld = 1'b1;
            e_val = model_merge(idx, en, d);
            exp_regs[idx] = e_val;
            m_mask = '0;
        end else if (en[2:0] != 0) begin
            if (m_mask == 0) begin
                m_tag  = idx;
                m_mask = en[2:0];
                for (int k = 0; k < 3; k++) if (en[k]) m_dw[k] = d[k*DW +: DW];
            end else if (m_tag == idx) begin
                m_mask = m_mask | en[2:0];
                for (int k = 0; k < 3; k++) if (en[k]) m_dw[k] = d[k*DW +: DW];
            end
        end
        @(posedge clk);
        @(negedge clk);
        host_vld = 1'b0;
        check({req, " strobe"}, RW'(commit_vld), RW'(e_vld));
        if (e_vld) begin
            check({req, " index"}, RW'(commit_idx), RW'(idx));
            check({req, " data"}, commit_data, e_val);
        end
        check({req, " array"}, peek_data, exp_regs[idx]);
    endtask

    function automatic logic [RW-1:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [RW-1:0] v;
        void'($urandom(32'h5EED_2024));
        for (int r = 0; r < NUM_REGS; r++) exp_regs[r] = '0;
        m_mask = '0;
        m_tag  = '0;
        for (int k = 0; k < 3; k++) m_dw[k] = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int r = 0; r < NUM_REGS; r++) begin
            peek_idx = IW'(r);
            #1;
            check("R1 array zero", peek_data, '0);
        end
        check("R1 strobe low", RW'(commit_vld), '0);

        // R1 / R3: a bare top dword right after reset commits zeros below
        beat("R3 top only", 3'd2, 4'b1000, rnd128());

        // R4, R5, R3: single dwords merged, dword 1 missing
        beat("R4 capture", 3'd1, 4'b0001, rnd128());
        beat("R5 overwrite", 3'd1, 4'b0001, rnd128());
        beat("R5 add", 3'd1, 4'b0100, rnd128());
        // R6: other register discarded while filling
        beat("R6 discard", 3'd5, 4'b0111, rnd128());
        beat("R3 commit merged", 3'd1, 4'b1000, rnd128());

        // R9: buffer empty after commit, another register captured
        beat("R9 capture after commit", 3'd5, 4'b0010, rnd128());
        beat("R9 commit", 3'd5, 4'b1000, rnd128());
        // R9: back-to-back commits, strobe falls after
        beat("R9 b2b a", 3'd0, 4'b1111, rnd128());
        beat("R9 b2b b", 3'd0, 4'b1000, rnd128());
        beat("R11 idle", 3'd0, 4'b0000, rnd128());

        // R7: three- and four-dword beats
        beat("R7 four", 3'd3, 4'b1111, rnd128());
        beat("R7 three low", 3'd4, 4'b0111, rnd128());
        beat("R7 commit", 3'd4, 4'b1000, rnd128());
        beat("R7 one low", 3'd6, 4'b0010, rnd128());
        beat("R7 three top", 3'd6, 4'b1101, rnd128());

        // R8: two 64-bit halves
        beat("R8 low half", 3'd7, 4'b0011, rnd128());
        beat("R8 high half", 3'd7, 4'b1100, rnd128());

        // R10: top beat to another register ignores buffer and empties it
        beat("R10 fill", 3'd2, 4'b0111, rnd128());
        beat("R10 foreign top", 3'd3, 4'b1000, rnd128());
        beat("R10 recapture", 3'd6, 4'b0001, rnd128());
        beat("R10 commit", 3'd6, 4'b1000, rnd128());

        // R11: enable-less beat while filling leaves buffer intact
        beat("R11 fill", 3'd1, 4'b0110, rnd128());
        beat("R11 no lanes", 3'd1, 4'b0000, rnd128());
        beat("R11 commit", 3'd1, 4'b1000, rnd128());

        // random mix over a few registers (R2 R3 R5 R6 R7)
        for (int n = 0; n < 600; n++) begin
            logic [IW-1:0] ri;
            logic [3:0]    re;
            ri = IW'($urandom % 3);
            re = 4'($urandom);
            if (($urandom % 4) == 0) re[3] = 1'b0;
            v = rnd128();
            beat("R2 random", ri, re, v);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule